// File: doc/BRIEF.md
# Segmented Flash Array Controller

This block models an on-chip non-volatile code store together with its command logic. The array is a register file of 32-bit entries, so every read returns a whole double word one cycle after the request. Program and block-erase commands go through a small command port. A down-counter stands in for the long program and erase times, and `busy_o` is held high while it runs. Programming only clears bits. Erasing returns the cells of one block to all ones.

The array is divided into sixteen equal units of `2**UNIT_LG` entries. Units are grouped into four erase blocks of 6, 6, 3 and 1 units, in ascending address order. With `UNIT_LG = 9` the array holds 8192 entries (32 KB), and the blocks are 12, 12, 6 and 2 KB. On the first clock after reset the array is mapped to segment 0 (base 0x00000) or segment 1 (base 0x10000). That choice then stays fixed. A sticky read-protection mode replaces the data of any read whose requesting fetch address (`src_addr_i`) lies outside the array with a fixed value. Reads requested by code running inside the array still return the stored data.

Top module: `flash_ctrl`

## Requirements
- R1: A read request for an aligned byte address inside the mapped range (`rd_addr_i[1:0] == 0`) gives `rd_valid_o = 1` on the next cycle. `rd_data_o` then holds the full 32-bit entry at index `(rd_addr_i - base) >> 2`.
- R2: After reset every entry reads as 32'hFFFF_FFFF.
- R3: `seg_sel_i` is captured on the first clock after reset release and is shown on `seg_o`. The base is 0x00000 when it is 0 and 0x10000 when it is 1, and the mapped range spans `64 << UNIT_LG` bytes. Later changes of `seg_sel_i` have no effect. Reads outside the mapped range give no `rd_valid_o`.
- R4: Programming ANDs the write data into the entry. Op 3'b010 programs the whole entry with `cmd_data_i`. Op 3'b001 programs one 16-bit half with `cmd_data_i[15:0]`: the upper half when `cmd_addr_i[1]` is 1, the lower half when it is 0.
- R5: An accepted program holds `busy_o` high for exactly `PROG_CYCLES` cycles, and an accepted erase holds it high for exactly `ERASE_CYCLES` cycles. In both cases `busy_o` rises in the cycle after the command, and the array changes when `busy_o` falls.
- R6: While `busy_o` is high, read requests give no `rd_valid_o`. Commands issued while busy are rejected: they set `err_o` and leave the array unchanged.
- R7: The following commands are rejected with `err_o` set and leave `busy_o` low: a program or erase while `vpp_i` is low, a command address outside the array or with bit 0 set, and op codes 3'b000 or 3'b101 through 3'b111. The next accepted command clears `err_o`.
- R8: Op 3'b011 erases the whole block that contains `cmd_addr_i` to all ones. Blocks cover units 0–5, 6–11, 12–14 and 15. Other blocks are untouched.
- R9: Op 3'b100 sets `prot_o` without needing `vpp_i` and without going busy. While `prot_o` is high, a read whose `src_addr_i` lies outside the mapped range returns `PROT_VALUE` (default 0) with `rd_valid_o`. A read whose `src_addr_i` lies inside the range returns the stored entry.
- R10: `prot_o` is cleared only by reset, or when each of the four blocks has been erased at least once since protection was last set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seg_sel_i | input | 1 | Segment choice, captured once after reset |
| vpp_i | input | 1 | Programming voltage present |
| cmd_we_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code |
| cmd_addr_i | input | 18 | Command byte address |
| cmd_data_i | input | 32 | Program data |
| rd_req_i | input | 1 | Read request |
| rd_addr_i | input | 18 | Read byte address |
| src_addr_i | input | 18 | Fetch address of the requester |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| busy_o | output | 1 | Program or erase in progress |
| err_o | output | 1 | Last command rejected |
| prot_o | output | 1 | Read protection active |
| seg_o | output | 1 | Mapped segment |

## Verification
The assertions assume that `cmd_op_i`, `vpp_i` and `cmd_we_i` are stable around the sampling edge. They also assume that `PROG_CYCLES` and `ERASE_CYCLES` are at least 1, so the busy-length window always closes. The stimulus drives every input on the falling edge and uses a small array of 64 entries with short timings, so that every entry can be swept. The bench only issues commands as single-cycle strobes. The one deliberate exception is a command and a read placed during a busy window, which checks that both are rejected.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;
  localparam int ADDR_W = 18;

  typedef enum logic [2:0] {
    OP_NONE   = 3'b000,
    OP_PROG16 = 3'b001,
    OP_PROG32 = 3'b010,
    OP_ERASE  = 3'b011,
    OP_PROT   = 3'b100
  } op_e;

  // unit index (16 units) -> erase block, sizes 6/6/3/1 ascending
  function automatic logic [1:0] blk_of(input logic [3:0] unit);
    if (unit < 4'd6)       return 2'd0;
    else if (unit < 4'd12) return 2'd1;
    else if (unit < 4'd15) return 2'd2;
    else                   return 2'd3;
  endfunction
endpackage

// File: rtl/flash_addr_map.sv
module flash_addr_map
  import flash_ctrl_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              seg_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              half_o
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 << IDX_W);
  logic [ADDR_W-1:0] base;

  assign base   = seg_i ? ADDR_W'(18'h10000) : '0;
  assign hit_o  = (addr_i >= base) && (addr_i < base + SPAN) && !addr_i[0];
  assign idx_o  = addr_i[IDX_W+1:2];
  assign half_o = addr_i[1];
endmodule

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= load_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_ctrl_pkg::*;
#(
  parameter int UNIT_LG = 4,
  localparam int IDX_W  = UNIT_LG + 4,
  localparam int WORDS  = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_i,
  input  logic [IDX_W-1:0] prog_idx_i,
  input  logic [31:0]      prog_mask_i,
  input  logic             erase_i,
  input  logic [1:0]       erase_blk_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [31:0]      rd_word_o
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (erase_i && blk_of(4'(i >> UNIT_LG)) == erase_blk_i)
          mem[i] <= '1;
        else if (prog_i && prog_idx_i == IDX_W'(i))
          mem[i] <= mem[i] & prog_mask_i;
      end
    end
  end

  assign rd_word_o = mem[rd_idx_i];
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_ctrl_pkg::*;
#(
  parameter int          UNIT_LG      = 4,
  parameter int          PROG_CYCLES  = 2000,
  parameter int          ERASE_CYCLES = 20000000,
  parameter logic [31:0] PROT_VALUE   = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        seg_sel_i,
  input  logic        vpp_i,
  input  logic        cmd_we_i,
  input  logic [2:0]  cmd_op_i,
  input  logic [17:0] cmd_addr_i,
  input  logic [31:0] cmd_data_i,
  input  logic        rd_req_i,
  input  logic [17:0] rd_addr_i,
  input  logic [17:0] src_addr_i,
  output logic        rd_valid_o,
  output logic [31:0] rd_data_o,
  output logic        busy_o,
  output logic        err_o,
  output logic        prot_o,
  output logic        seg_o
);
  localparam int IDX_W   = UNIT_LG + 4;
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 << IDX_W);

  logic init_q, seg_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
      seg_q  <= 1'b0;
    end else if (!init_q) begin
      init_q <= 1'b1;
      seg_q  <= seg_sel_i;
    end
  end
  assign seg_o = seg_q;

  logic             rd_hit, rd_half, cmd_hit, cmd_half, src_hit;
  logic [IDX_W-1:0] rd_idx, cmd_idx;
  logic [ADDR_W-1:0] base;

  flash_addr_map #(.IDX_W(IDX_W)) i_rd_map (
    .addr_i(rd_addr_i), .seg_i(seg_q), .hit_o(rd_hit), .idx_o(rd_idx), .half_o(rd_half));
  flash_addr_map #(.IDX_W(IDX_W)) i_cmd_map (
    .addr_i(cmd_addr_i), .seg_i(seg_q), .hit_o(cmd_hit), .idx_o(cmd_idx), .half_o(cmd_half));

  assign base    = seg_q ? ADDR_W'(18'h10000) : '0;
  assign src_hit = (src_addr_i >= base) && (src_addr_i < base + SPAN);

  // command decode
  op_e  op;
  logic needs_vpp, op_known, cmd_ok, seq_start, seq_done, busy;
  assign op        = op_e'(cmd_op_i);
  assign needs_vpp = (op == OP_PROG16) || (op == OP_PROG32) || (op == OP_ERASE);
  assign op_known  = needs_vpp || (op == OP_PROT);
  assign cmd_ok    = cmd_we_i && init_q && !busy && op_known &&
                     (!needs_vpp || (vpp_i && cmd_hit));
  assign seq_start = cmd_ok && needs_vpp;

  flash_seq #(.CNT_W(CNT_W)) i_seq (
    .clk_i, .rst_ni,
    .start_i (seq_start),
    .load_i  ((op == OP_ERASE) ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1)),
    .busy_o  (busy),
    .done_o  (seq_done)
  );
  assign busy_o = busy;

  // operation held until the timer expires
  logic             pend_prog;
  logic [IDX_W-1:0] pend_idx;
  logic [31:0]      pend_mask, new_mask;
  logic [1:0]       pend_blk;

  always_comb begin
    new_mask = cmd_data_i;
    if (op == OP_PROG16)
      new_mask = cmd_half ? {cmd_data_i[15:0], 16'hFFFF} : {16'hFFFF, cmd_data_i[15:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_prog <= 1'b0;
      pend_idx  <= '0;
      pend_mask <= '1;
      pend_blk  <= '0;
    end else if (seq_start) begin
      pend_prog <= (op != OP_ERASE);
      pend_idx  <= cmd_idx;
      pend_mask <= new_mask;
      pend_blk  <= blk_of(cmd_idx[IDX_W-1:UNIT_LG]);
    end
  end

  logic        do_prog, do_erase;
  logic [31:0] arr_word;
  assign do_prog  = seq_done && pend_prog;
  assign do_erase = seq_done && !pend_prog;

  flash_array #(.UNIT_LG(UNIT_LG)) i_array (
    .clk_i, .rst_ni,
    .prog_i      (do_prog),
    .prog_idx_i  (pend_idx),
    .prog_mask_i (pend_mask),
    .erase_i     (do_erase),
    .erase_blk_i (pend_blk),
    .rd_idx_i    (rd_idx),
    .rd_word_o   (arr_word)
  );

  // error flag, protection and its erase tracking
  logic       err_q, prot_q;
  logic [3:0] wiped_q, wiped_nxt;
  assign wiped_nxt = wiped_q | (4'b0001 << pend_blk);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= 1'b0;
      prot_q  <= 1'b0;
      wiped_q <= '0;
    end else begin
      if (cmd_we_i && !cmd_ok) err_q <= 1'b1;
      else if (cmd_ok)         err_q <= 1'b0;
      if (cmd_ok && op == OP_PROT) begin
        prot_q  <= 1'b1;
        wiped_q <= '0;
      end else if (do_erase) begin
        if (&wiped_nxt) begin
          prot_q  <= 1'b0;
          wiped_q <= '0;
        end else begin
          wiped_q <= wiped_nxt;
        end
      end
    end
  end
  assign err_o  = err_q;
  assign prot_o = prot_q;

  // read port, one cycle latency
  logic        rd_ok, rd_valid_q;
  logic [31:0] rd_data_q;
  assign rd_ok = rd_req_i && init_q && !busy && rd_hit && !rd_half;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_ok;
      if (rd_ok) rd_data_q <= (prot_q && !src_hit) ? PROT_VALUE : arr_word;
    end
  end
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
endmodule

// File: rtl/flash_ctrl_chk.sv
module flash_ctrl_chk
  import flash_ctrl_pkg::*;
#(
  parameter int PROG_CYCLES  = 2000,
  parameter int ERASE_CYCLES = 20000000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_we_i,
  input logic [2:0] cmd_op_i,
  input logic       vpp_i,
  input logic       busy_o,
  input logic       rd_valid_o,
  input logic       err_o,
  input logic       prot_o,
  input logic       seg_o,
  input logic       init_q,
  input logic       start_i
);
  int run_cnt, exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt <= 0;
      exp_q   <= 0;
    end else begin
      run_cnt <= busy_o ? run_cnt + 1 : 0;
      if (start_i) exp_q <= (cmd_op_i == OP_ERASE) ? ERASE_CYCLES : PROG_CYCLES;
    end
  end

  p_busy_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_cnt == exp_q);

  p_no_read_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !rd_valid_o);

  p_cmd_busy_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && busy_o |=> err_o);

  p_no_vpp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && init_q && !busy_o && !vpp_i && (cmd_op_i inside {3'b001, 3'b010, 3'b011})
    |=> err_o && !busy_o);

  p_seg_fixed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q && $past(init_q) |-> $stable(seg_o));

  p_prot_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prot_o) |-> $past(busy_o));
endmodule

bind flash_ctrl flash_ctrl_chk #(
  .PROG_CYCLES  (PROG_CYCLES),
  .ERASE_CYCLES (ERASE_CYCLES)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_we_i   (cmd_we_i),
  .cmd_op_i   (cmd_op_i),
  .vpp_i      (vpp_i),
  .busy_o     (busy_o),
  .rd_valid_o (rd_valid_o),
  .err_o      (err_o),
  .prot_o     (prot_o),
  .seg_o      (seg_o),
  .init_q     (init_q),
  .start_i    (seq_start)
);

// File: tb/test_flash_ctrl.sv
module test_flash_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT_LG    = 2;
  localparam int WORDS      = 16 << UNIT_LG;
  localparam int PROG       = 3;
  localparam int ERASE      = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_sel = 1'b0, vpp = 1'b1, cmd_we = 1'b0, rd_req = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [17:0] cmd_addr = '0, rd_addr = '0, src_addr = '0;
  logic [31:0] cmd_data = '0;
  logic        rd_valid, busy, err, prot, seg;
  logic [31:0] rd_data;

  int n_chk = 0, n_err = 0;
  logic [31:0] mdl [WORDS];
  logic [17:0] base;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_ctrl #(
    .UNIT_LG(UNIT_LG), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE), .PROT_VALUE(32'h0)
  ) i_flash_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .seg_sel_i(seg_sel), .vpp_i(vpp),
    .cmd_we_i(cmd_we), .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data),
    .rd_req_i(rd_req), .rd_addr_i(rd_addr), .src_addr_i(src_addr),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .busy_o(busy), .err_o(err),
    .prot_o(prot), .seg_o(seg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int blk(input int w);
    int u = w >> UNIT_LG;
    return (u < 6) ? 0 : (u < 12) ? 1 : (u < 15) ? 2 : 3;
  endfunction

  function automatic logic [17:0] waddr(input int w);
    return 18'(base + 18'(w * 4));
  endfunction

  task automatic do_reset(input logic s);
    rst_n = 1'b0; seg_sel = s;
    @(negedge clk); @(negedge clk);
    check("reset busy", 32'(busy), 0);
    check("reset err", 32'(err), 0);
    check("reset prot R10", 32'(prot), 0);
    check("reset valid", 32'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    base = s ? 18'h10000 : 18'h0;
    for (int i = 0; i < WORDS; i++) mdl[i] = '1;
    check("R3 seg latched", 32'(seg), 32'(s));
  endtask

  task automatic do_rd(input logic [17:0] a, input logic [17:0] s,
                       output logic v, output logic [31:0] d);
    rd_req = 1'b1; rd_addr = a; src_addr = s;
    @(posedge clk); @(negedge clk);
    rd_req = 1'b0;
    v = rd_valid; d = rd_data;
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [17:0] a, input logic [31:0] d);
    cmd_we = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(posedge clk); @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic sweep(input string req, input logic [17:0] s);
    logic v; logic [31:0] d;
    for (int i = 0; i < WORDS; i++) begin
      do_rd(waddr(i), s, v, d);
      check({req, " valid"}, 32'(v), 1);
      check(req, d, mdl[i]);
    end
  endtask

  task automatic erase_blk(input int b);
    int n;
    int first = (b == 0) ? 0 : (b == 1) ? 6 : (b == 2) ? 12 : 15;
    do_cmd(3'b011, waddr(first << UNIT_LG), '0);
    wait_idle(n);
    check("R5 erase busy length", n, ERASE);
    for (int i = 0; i < WORDS; i++) if (blk(i) == b) mdl[i] = '1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic v; logic [31:0] d, pat; int n;
    base = '0;
    do_reset(1'b1);
    sweep("R2 erased contents", base + 18'h4);

    // R3: later select changes and out-of-range reads
    seg_sel = 1'b0;
    @(negedge clk);
    check("R3 seg fixed", 32'(seg), 1);
    do_rd(18'h00000, base, v, d);
    check("R3 other segment no valid", 32'(v), 0);
    do_rd(18'(base + 18'(WORDS * 4)), base, v, d);
    check("R3 past end no valid", 32'(v), 0);

    // R4/R5: double-word programming on every entry
    for (int i = 0; i < WORDS; i++) begin
      pat = ~(32'h1 << (i % 32)) ^ (32'(i) << 8);
      do_cmd(3'b010, waddr(i), pat);
      check("R5 busy after program", 32'(busy), 1);
      wait_idle(n);
      check("R5 program busy length", n, PROG);
      mdl[i] = mdl[i] & pat;
    end
    sweep("R1 R4 dword program", base);

    // R4: half-word programming, upper and lower
    for (int i = 0; i < 8; i++) begin
      do_cmd(3'b001, waddr(i) + 18'h2, 32'hABCD_0F0F);
      wait_idle(n);
      mdl[i] = mdl[i] & 32'h0F0F_FFFF;
      do_cmd(3'b001, waddr(i + 8), 32'h1234_F00F);
      wait_idle(n);
      mdl[i + 8] = mdl[i + 8] & 32'hFFFF_F00F;
    end
    sweep("R4 half program", base);

    // R6: command and read while busy
    do_cmd(3'b010, waddr(20), 32'h00FF_00FF);
    mdl[20] = mdl[20] & 32'h00FF_00FF;
    cmd_we = 1'b1; cmd_op = 3'b010; cmd_addr = waddr(21); cmd_data = 32'h0;
    rd_req = 1'b1; rd_addr = waddr(21); src_addr = base;
    @(posedge clk); @(negedge clk);
    cmd_we = 1'b0; rd_req = 1'b0;
    check("R6 cmd while busy err", 32'(err), 1);
    check("R6 read while busy no valid", 32'(rd_valid), 0);
    wait_idle(n);
    do_rd(waddr(21), base, v, d);
    check("R6 busy cmd no effect", d, mdl[21]);
    do_rd(waddr(20), base, v, d);
    check("R4 first cmd applied", d, mdl[20]);

    // R7: no voltage, bad op, bad address
    vpp = 1'b0;
    do_cmd(3'b010, waddr(30), 32'h0);
    check("R7 no vpp err", 32'(err), 1);
    check("R7 no vpp idle", 32'(busy), 0);
    do_cmd(3'b011, waddr(30), 32'h0);
    check("R7 erase no vpp idle", 32'(busy), 0);
    vpp = 1'b1;
    do_rd(waddr(30), base, v, d);
    check("R7 rejected no effect", d, mdl[30]);
    do_cmd(3'b010, waddr(30), 32'hFFFF_FF00);
    check("R7 accepted clears err", 32'(err), 0);
    wait_idle(n);
    mdl[30] = mdl[30] & 32'hFFFF_FF00;
    do_cmd(3'b111, waddr(30), 32'h0);
    check("R7 bad op err", 32'(err), 1);
    do_cmd(3'b010, 18'h00010, 32'h0);
    check("R7 out of range err", 32'(err), 1);
    check("R7 out of range idle", 32'(busy), 0);
    do_cmd(3'b010, waddr(31) + 18'h1, 32'h0);
    check("R7 odd address err", 32'(err), 1);

    // R8: single block erase
    erase_blk(1);
    sweep("R8 block erase", base);

    // R9: protection
    do_cmd(3'b100, '0, '0);
    check("R9 prot set", 32'(prot), 1);
    check("R9 prot not busy", 32'(busy), 0);
    for (int i = 0; i < WORDS; i++) begin
      do_rd(waddr(i), 18'h00100, v, d);
      check("R9 outside valid", 32'(v), 1);
      check("R9 outside masked", d, 32'h0);
    end
    sweep("R9 inside read", base + 18'h8);

    // R10: sticky until all four blocks erased
    erase_blk(0);
    erase_blk(2);
    erase_blk(3);
    check("R10 prot held after three", 32'(prot), 1);
    erase_blk(1);
    check("R10 prot cleared", 32'(prot), 0);
    sweep("R10 outside read after clear", 18'h00100);

    // segment 0 mapping, and reset clears protection
    do_reset(1'b0);
    do_cmd(3'b100, '0, '0);
    check("R9 prot set seg0", 32'(prot), 1);
    do_rd(18'h10000, 18'h0, v, d);
    check("R3 seg1 addr no valid", 32'(v), 0);
    sweep("R3 seg0 inside read", 18'h0);
    do_reset(1'b0);
    check("R10 reset clears prot", 32'(prot), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule